// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power State Tracker

This block sits on the controller side of a single-data-rate synchronous DRAM interface. It watches the clock-enable pin, the four active-low command pins and a per-bank idle vector on every rising clock edge. From these it follows the low-power condition of the memory device: normal operation, self refresh, power down or clock suspend. It keeps the clock-enable level from the previous cycle. Each decision depends on the pair (previous CKE, current CKE), on the current state and on the command in the cycle.

The block flags commands that the device would not accept in its present condition as illegal. It flags a clock-enable history that cannot occur in a low-power state as invalid. For each sampled cycle it reports a decoded action code. All outputs are registered and show the result of the inputs one clock after those inputs were sampled. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `sdram_lp_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state output is normal (code 0), the action output is none (code 0) and both flags are low. The previous CKE is taken as high after reset.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0111 is a no-operation, 0001 is auto refresh, 0000 is mode register set, and cs_n=1 is deselect whatever the other three pins carry. In normal state with CKE high in both cycles and all banks idle, auto refresh reports action 2 and any other legal command reports action 0.
- R3: In self refresh (state 1) or power down (state 2), with CKE low in both the previous and the current cycle, the state is held and any command is ignored. The action is 4 for self refresh and 7 for power down.
- R4: In self refresh, a low-to-high CKE change with a deselect or no-operation returns the state to normal with action 5. With any other command the illegal flag rises, the action is 12 and the state stays in self refresh.
- R5: In power down, a low-to-high CKE change with a deselect or no-operation returns the state to normal with action 8. Any other command raises the illegal flag, gives action 12 and leaves the state in power down.
- R6: In self refresh or power down, a cycle whose previous CKE was high raises the invalid flag with action 13, and the state is unchanged.
- R7: In normal state with all banks idle, a high-to-low CKE change enters self refresh (action 3) when the command is auto refresh. With any other command it enters power down (action 6).
- R8: In normal state with at least one bank active, a high-to-low CKE change enters clock suspend (state 3) with action 9. If the command in that cycle is auto refresh or mode register set, the state still moves to clock suspend, the illegal flag rises and the action is 12. Self refresh and power down are never entered while a bank is active.
- R9: A mode register set in normal state with CKE high in both cycles reports action 1 when all banks are idle. When a bank is active it raises the illegal flag and reports action 12.
- R10: In clock suspend, CKE low holds the state with action 10. CKE high returns the state to normal on the next output with action 11.
- R11: Each flag is a registered pulse that lasts only for the cycle it describes. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_idle | input | NUM_BANKS | One bit per bank, high when that bank is idle |
| state_o | output | 2 | 0 normal, 1 self refresh, 2 power down, 3 clock suspend |
| action_o | output | 4 | Decoded action code of the previous sampled cycle |
| illegal_o | output | 1 | Pulse: the command was not allowed in that condition |
| invalid_o | output | 1 | Pulse: the CKE history cannot occur in that state |

## Verification
The assertions assume that CKE and the bank idle vector are stable, defined values at each rising edge, and that reset lasts at least one edge. They also assume the bank idle vector reflects the banks as the controller believes them to be. They do not check whether that belief is correct. The stimulus changes every input only on the falling clock edge and drives CKE high during reset. It reaches the unreachable combinations, such as a high previous CKE in power down, only through the illegal exit path that the design itself permits.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_SELF_REF = 2'd1,
    ST_PWR_DOWN = 2'd2,
    ST_SUSPEND  = 2'd3
  } lp_state_e;

  typedef enum logic [3:0] {
    ACT_NONE      = 4'd0,
    ACT_MRS       = 4'd1,
    ACT_AUTO_REF  = 4'd2,
    ACT_SR_ENTER  = 4'd3,
    ACT_SR_HOLD   = 4'd4,
    ACT_SR_EXIT   = 4'd5,
    ACT_PD_ENTER  = 4'd6,
    ACT_PD_HOLD   = 4'd7,
    ACT_PD_EXIT   = 4'd8,
    ACT_CS_BEGIN  = 4'd9,
    ACT_CS_HOLD   = 4'd10,
    ACT_CS_END    = 4'd11,
    ACT_ILLEGAL   = 4'd12,
    ACT_INVALID   = 4'd13
  } lp_action_e;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_MRS   = 3'd3,
    CMD_OTHER = 3'd4
  } cmd_kind_e;

  typedef struct packed {
    lp_state_e  state;
    lp_action_e action;
    logic       illegal;
    logic       invalid;
  } lp_decision_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_lp_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind
);
  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    if (cs_n) begin
      kind = CMD_DESEL;
    end else begin
      unique case (strobes)
        3'b111:  kind = CMD_NOP;
        3'b001:  kind = CMD_AREF;
        3'b000:  kind = CMD_MRS;
        default: kind = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_idle_reduce.sv
module sdram_bank_idle_reduce #(
  parameter int NUM_BANKS = 4
) (
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic                 all_idle
);
  localparam int LAST = NUM_BANKS - 1;

  generate
    if (NUM_BANKS == 1) begin : g_single
      assign all_idle = bank_idle[0];
    end else begin : g_chain
      logic [LAST:0] acc;
      assign acc[0] = bank_idle[0];
      for (genvar b = 1; b < NUM_BANKS; b++) begin : g_and
        assign acc[b] = acc[b-1] & bank_idle[b];
      end
      assign all_idle = acc[LAST];
    end
  endgenerate
endmodule

// File: rtl/sdram_lp_next.sv
module sdram_lp_next
  import sdram_lp_pkg::*;
(
  input  lp_state_e    cur_state,
  input  logic         prev_cke,
  input  logic         cke,
  input  cmd_kind_e    kind,
  input  logic         all_idle,
  output lp_decision_t dec
);
  logic exit_ok;
  assign exit_ok = (kind == CMD_DESEL) || (kind == CMD_NOP);

  always_comb begin
    dec.state   = cur_state;
    dec.action  = ACT_NONE;
    dec.illegal = 1'b0;
    dec.invalid = 1'b0;
    unique case (cur_state)
      ST_SELF_REF, ST_PWR_DOWN: begin
        if (prev_cke) begin
          dec.action  = ACT_INVALID;
          dec.invalid = 1'b1;
        end else if (!cke) begin
          dec.action = (cur_state == ST_SELF_REF) ? ACT_SR_HOLD : ACT_PD_HOLD;
        end else if (exit_ok) begin
          dec.state  = ST_NORMAL;
          dec.action = (cur_state == ST_SELF_REF) ? ACT_SR_EXIT : ACT_PD_EXIT;
        end else begin
          dec.action  = ACT_ILLEGAL;
          dec.illegal = 1'b1;
        end
      end
      ST_SUSPEND: begin
        if (cke) begin
          dec.state  = ST_NORMAL;
          dec.action = ACT_CS_END;
        end else begin
          dec.action = ACT_CS_HOLD;
        end
      end
      default: begin
        if (cke) begin
          if (kind == CMD_MRS) begin
            if (all_idle) begin
              dec.action = ACT_MRS;
            end else begin
              dec.action  = ACT_ILLEGAL;
              dec.illegal = 1'b1;
            end
          end else if (kind == CMD_AREF) begin
            dec.action = ACT_AUTO_REF;
          end
        end else if (prev_cke) begin
          if (all_idle) begin
            if (kind == CMD_AREF) begin
              dec.state  = ST_SELF_REF;
              dec.action = ACT_SR_ENTER;
            end else begin
              dec.state  = ST_PWR_DOWN;
              dec.action = ACT_PD_ENTER;
            end
          end else begin
            dec.state = ST_SUSPEND;
            if ((kind == CMD_AREF) || (kind == CMD_MRS)) begin
              dec.action  = ACT_ILLEGAL;
              dec.illegal = 1'b1;
            end else begin
              dec.action = ACT_CS_BEGIN;
            end
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/sdram_lp_tracker.sv
module sdram_lp_tracker
  import sdram_lp_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic [1:0]           state_o,
  output logic [3:0]           action_o,
  output logic                 illegal_o,
  output logic                 invalid_o
);
  cmd_kind_e    kind;
  logic         all_idle;
  lp_decision_t dec;

  lp_state_e  state_q;
  lp_action_e action_q;
  logic       prev_cke_q;
  logic       illegal_q;
  logic       invalid_q;

  sdram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .kind  (kind)
  );

  sdram_bank_idle_reduce #(.NUM_BANKS(NUM_BANKS)) u_idle (
    .bank_idle (bank_idle),
    .all_idle  (all_idle)
  );

  sdram_lp_next u_next (
    .cur_state (state_q),
    .prev_cke  (prev_cke_q),
    .cke       (cke),
    .kind      (kind),
    .all_idle  (all_idle),
    .dec       (dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_NORMAL;
      action_q   <= ACT_NONE;
      prev_cke_q <= 1'b1;
      illegal_q  <= 1'b0;
      invalid_q  <= 1'b0;
    end else begin
      state_q    <= dec.state;
      action_q   <= dec.action;
      prev_cke_q <= cke;
      illegal_q  <= dec.illegal;
      invalid_q  <= dec.invalid;
    end
  end

  assign state_o   = state_q;
  assign action_o  = action_q;
  assign illegal_o = illegal_q;
  assign invalid_o = invalid_q;
endmodule

// File: rtl/sdram_lp_tracker_chk.sv
module sdram_lp_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic [NUM_BANKS-1:0] bank_idle,
  input logic [1:0]           state_o,
  input logic                 illegal_o,
  input logic                 invalid_o
);
  localparam logic [1:0] S_NORM = 2'd0;
  localparam logic [1:0] S_SR   = 2'd1;
  localparam logic [1:0] S_PD   = 2'd2;
  localparam logic [1:0] S_CS   = 2'd3;

  p_sr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SR && !cke) |=> (state_o == S_SR));

  p_pd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_PD && !cke) |=> (state_o == S_PD));

  p_invalid_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> ($past(state_o) == S_SR || $past(state_o) == S_PD));

  p_busy_no_lowpwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_NORM && !(&bank_idle)) |=> (state_o != S_SR && state_o != S_PD));

  p_cs_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_CS && cke) |=> (state_o == S_NORM));

  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_o, invalid_o}));
endmodule

bind sdram_lp_tracker sdram_lp_tracker_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .bank_idle (bank_idle),
  .state_o   (state_o),
  .illegal_o (illegal_o),
  .invalid_o (invalid_o)
);

// File: tb/sdram_lp_tracker_tb_top.sv
module sdram_lp_tracker_tb_top;
  localparam int NB = 4;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_DES = 4'b1010;
  localparam logic [3:0] C_OTH = 4'b0011;
  localparam logic [NB-1:0] IDLE = '1;
  localparam logic [NB-1:0] BUSY = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic [3:0] cmd = C_NOP;
  logic [NB-1:0] bank_idle = IDLE;
  logic [1:0] state_o;
  logic [3:0] action_o;
  logic illegal_o, invalid_o;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [1:0] st;
    logic [3:0] act;
    logic ill;
    logic inv;
    string req;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_state = 2'd0;
  logic m_prev = 1'b1;

  always #5 clk = ~clk;

  sdram_lp_tracker #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .cs_n(cmd[3]), .ras_n(cmd[2]), .cas_n(cmd[1]), .we_n(cmd[0]),
    .bank_idle(bank_idle), .state_o(state_o), .action_o(action_o),
    .illegal_o(illegal_o), .invalid_o(invalid_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  // Expected outcome written from the requirement text.
  task automatic step(input logic k, input logic [3:0] c,
                      input logic [NB-1:0] idl, input string req);
    exp_t e;
    bit ex_ok, all_i;
    @(negedge clk);
    cke = k; cmd = c; bank_idle = idl;
    ex_ok = c[3] || (c == C_NOP);
    all_i = &idl;
    e.st = m_state; e.act = 4'd0; e.ill = 1'b0; e.inv = 1'b0; e.req = req;
    if (m_state == 2'd1 || m_state == 2'd2) begin
      if (m_prev) begin e.act = 4'd13; e.inv = 1'b1; end
      else if (!k) e.act = (m_state == 2'd1) ? 4'd4 : 4'd7;
      else if (ex_ok) begin e.st = 2'd0; e.act = (m_state == 2'd1) ? 4'd5 : 4'd8; end
      else begin e.act = 4'd12; e.ill = 1'b1; end
    end else if (m_state == 2'd3) begin
      if (k) begin e.st = 2'd0; e.act = 4'd11; end else e.act = 4'd10;
    end else begin
      if (k) begin
        if (c == C_MRS) begin
          if (all_i) e.act = 4'd1; else begin e.act = 4'd12; e.ill = 1'b1; end
        end else if (c == C_REF) e.act = 4'd2;
      end else if (m_prev) begin
        if (all_i) begin
          if (c == C_REF) begin e.st = 2'd1; e.act = 4'd3; end
          else begin e.st = 2'd2; e.act = 4'd6; end
        end else begin
          e.st = 2'd3;
          if (c == C_REF || c == C_MRS) begin e.act = 4'd12; e.ill = 1'b1; end
          else e.act = 4'd9;
        end
      end
    end
    m_state = e.st;
    m_prev = k;
    q.push_back(e);
  endtask

  // Monitor: results appear one edge after the inputs were sampled.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(state_o == e.st, e.req, "state", state_o, e.st);
        check(action_o == e.act, e.req, "action", action_o, e.act);
        check(illegal_o == e.ill, e.req, "illegal", illegal_o, e.ill);
        check(invalid_o == e.inv, e.req, "invalid", invalid_o, e.inv);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(state_o == 2'd0, "R1", "reset state", state_o, 0);
    check(action_o == 4'd0, "R1", "reset action", action_o, 0);
    check(!illegal_o && !invalid_o, "R1", "reset flags", {illegal_o, invalid_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle low CKE relies on previous CKE taken as high
    step(1'b0, C_NOP, IDLE, "R1_R7 pd entry after reset");
    step(1'b1, C_NOP, IDLE, "R5 pd exit nop");
    // R2 decode in normal state
    step(1'b1, C_NOP, IDLE, "R2 nop");
    step(1'b1, C_REF, IDLE, "R2 auto refresh");
    step(1'b1, C_OTH, IDLE, "R2 other cmd");
    step(1'b1, 4'b1000, IDLE, "R2 deselect ignores strobes");
    // R9 mode register set
    step(1'b1, C_MRS, IDLE, "R9 mrs idle");
    step(1'b1, C_MRS, BUSY, "R9 mrs busy");
    step(1'b1, C_NOP, BUSY, "R11 flag drops");
    // R7 power down then illegal exit and invalid history
    step(1'b0, C_OTH, IDLE, "R7 pd entry other");
    step(1'b0, C_MRS, IDLE, "R3 pd hold ignores mrs");
    step(1'b0, C_REF, BUSY, "R3 pd hold ignores refresh");
    step(1'b1, C_REF, IDLE, "R5 pd illegal exit");
    step(1'b1, C_NOP, IDLE, "R6 invalid cke high");
    step(1'b0, C_NOP, IDLE, "R6 invalid prev high");
    step(1'b0, C_NOP, IDLE, "R3 pd hold");
    step(1'b1, C_DES, IDLE, "R5 pd exit deselect");
    // R7 self refresh
    step(1'b0, C_REF, IDLE, "R7 sr entry");
    step(1'b0, C_OTH, IDLE, "R3 sr hold ignores cmd");
    step(1'b1, C_MRS, IDLE, "R4 sr illegal exit");
    step(1'b0, C_NOP, IDLE, "R6 sr invalid");
    step(1'b0, C_NOP, IDLE, "R3 sr hold");
    step(1'b1, C_DES, IDLE, "R4 sr exit deselect");
    step(1'b1, C_NOP, IDLE, "R2 nop normal");
    step(1'b0, C_REF, IDLE, "R7 sr entry again");
    step(1'b1, C_NOP, IDLE, "R4 sr exit nop");
    // R8 busy bank: clock suspend
    step(1'b0, C_NOP, BUSY, "R8 suspend begin");
    step(1'b0, C_REF, BUSY, "R10 suspend hold");
    step(1'b0, C_NOP, IDLE, "R10 suspend hold idle");
    step(1'b1, C_NOP, BUSY, "R10 suspend end");
    step(1'b0, C_REF, BUSY, "R8 refresh with busy bank");
    step(1'b1, C_NOP, BUSY, "R10 suspend end");
    step(1'b0, C_MRS, BUSY, "R8 mrs with busy bank");
    step(1'b1, C_NOP, BUSY, "R11 flag one cycle");
    step(1'b1, C_NOP, IDLE, "R2 nop");
    repeat (3) @(posedge clk);
    #2;
    check(q.size() == 0, "R11", "queue drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule